// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs trap and interrupt entry for a small 32-bit RISC core. Each cycle it looks at one synchronous exception code from the pipeline and at two asynchronous requests: a device interrupt line and a tick-timer line. Each asynchronous line is gated by its own enable bit in the status register the block holds. When an entry is taken, the block does the following in one registered step:

- It stores the resume address.
- For illegal-instruction traps, it records the faulting address.
- It saves a snapshot of the status word.
- It moves the core into supervisor mode with translation and interrupts disabled.
- It drops the power-saving requests and kills the atomic reservation.
- It raises a translation-cache flush strobe.
- It sends fetch to a computed vector address.

The status word, the power-saving request pair and the reservation address are kept here. They are loaded through simple write strobes. An out-of-range synchronous code is not vectored. It produces an error pulse instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the status word reads 0x0001 (supervisor only), the reservation address reads all ones, the power-saving pair reads 0, the resume, fault and snapshot registers read 0, and no redirect, flush, clear or error pulse is driven.
- R2: A valid synchronous code from 1 to 14 produces, one clock later, a single-cycle redirect pulse with that code on the cause output. The resume address equals the PC when the instruction is not in a delay slot and the code is not 12.
- R3: With the delay-slot flag high, the resume address is PC minus 4, bit 5 (delay-slot-trap) is set in the new status word and in the snapshot, and a one-cycle delay-slot clear pulse is issued. With the flag low, bit 5 is cleared.
- R4: Code 12 (system call) adds 4 to the resume address after any delay-slot correction.
- R5: Code 7 (illegal instruction) loads the fault address register with the PC. Other codes leave it unchanged.
- R6: The snapshot equals the status word before entry, with bit 5 updated. The new status word sets bit 0 (supervisor), clears bit 1 (tick enable), bit 2 (interrupt enable), bit 3 (data translation) and bit 4 (instruction translation), and keeps every other bit, including bit 6 (high vector page).
- R7: The vector address is the code shifted left by 8. The base input is ORed in when the base-present input is high, and 0xF0000000 is ORed in when status bit 6 is set.
- R8: Without a synchronous exception, the tick line gives code 5 only if status bit 1 is set, and the device line gives code 8 only if status bit 2 is set. When both qualify, code 5 is taken. A request whose enable is clear causes no entry.
- R9: A valid synchronous exception is taken in preference to any interrupt arriving in the same cycle.
- R10: Every entry pulses the flush output for one cycle, clears the power-saving pair and sets the reservation address to all ones.
- R11: A valid synchronous code of 0 or 15 produces an error pulse one clock later. It produces no redirect and no flush, and leaves the status word and the reservation address as they were.
- R12: When no entry occurs, the status, power-saving and reservation write strobes load their data, which is visible one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Synchronous exception present this cycle |
| exc_code_i | input | 4 | Synchronous exception code |
| pc_i | input | 32 | PC of the excepting instruction |
| dslot_i | input | 1 | Instruction sits in a delay slot |
| ext_irq_i | input | 1 | Device interrupt request |
| tick_irq_i | input | 1 | Tick-timer interrupt request |
| vbase_en_i | input | 1 | Vector base register present |
| vbase_i | input | 32 | Vector base value |
| sr_wr_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 16 | Status word write data |
| pm_wr_i | input | 1 | Power-saving pair write strobe |
| pm_wdata_i | input | 2 | Power-saving write data (bit 0 doze, bit 1 sleep) |
| lock_set_i | input | 1 | Reservation address write strobe |
| lock_addr_i | input | 32 | Reservation address write data |
| redirect_o | output | 1 | Fetch redirect pulse |
| new_pc_o | output | 32 | Vector address of the last entry |
| cause_o | output | 4 | Code of the last entry |
| epc_o | output | 32 | Resume address |
| eear_o | output | 32 | Fault address |
| esr_o | output | 16 | Status snapshot |
| sr_o | output | 16 | Current status word |
| pm_o | output | 2 | Power-saving pair |
| lock_addr_o | output | 32 | Reservation address |
| tlb_flush_o | output | 1 | Translation cache flush pulse |
| dslot_clr_o | output | 1 | Delay-slot flag clear pulse |
| err_o | output | 1 | Unvectored code pulse |

## Verification
The properties assume that the status word is changed only through its write strobe, so the status value one cycle before an entry is the value the entry started from. They also assume that reset is held for at least one clock edge before the first request. The stimulus writes the status word in a cycle of its own, never together with an exception or an interrupt, and it holds reset for several cycles. Every request is driven for exactly one cycle, with all other request lines low unless a scenario needs them together.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [3:0] {
        EC_NONE     = 4'd0,
        EC_RESET    = 4'd1,
        EC_BUS      = 4'd2,
        EC_DPAGE    = 4'd3,
        EC_IPAGE    = 4'd4,
        EC_TICK     = 4'd5,
        EC_ALIGN    = 4'd6,
        EC_ILLEGAL  = 4'd7,
        EC_EXTINT   = 4'd8,
        EC_DTLB     = 4'd9,
        EC_ITLB     = 4'd10,
        EC_RANGE    = 4'd11,
        EC_SYSCALL  = 4'd12,
        EC_FPU      = 4'd13,
        EC_TRAP     = 4'd14
    } exc_code_e;

    localparam logic [3:0] EC_LAST = 4'd14;

    // status word bit positions
    localparam int SR_SUP      = 0;
    localparam int SR_TICK_EN  = 1;
    localparam int SR_IRQ_EN   = 2;
    localparam int SR_DMMU_EN  = 3;
    localparam int SR_IMMU_EN  = 4;
    localparam int SR_DSLOT_X  = 5;
    localparam int SR_HIGH_VEC = 6;
    localparam int SR_MIN_W    = 7;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          exc_valid,
    input  logic [CW-1:0] exc_code,
    input  logic          ext_irq,
    input  logic          tick_irq,
    input  logic          irq_en,
    input  logic          tick_en,
    output logic          take,
    output logic          bad,
    output logic [CW-1:0] code
);
    localparam logic [CW-1:0] FIRST = CW'(1);
    localparam logic [CW-1:0] LAST  = CW'(EC_LAST);

    logic in_range;
    logic tick_cand;
    logic ext_cand;

    assign in_range  = (exc_code >= FIRST) && (exc_code <= LAST);
    assign tick_cand = tick_irq && tick_en;
    assign ext_cand  = ext_irq && irq_en;

    always_comb begin
        take = 1'b0;
        bad  = 1'b0;
        code = '0;
        if (exc_valid) begin
            // synchronous trap always wins over interrupts
            take = in_range;
            bad  = !in_range;
            code = exc_code;
        end else if (tick_cand) begin
            take = 1'b1;
            code = CW'(EC_TICK);
        end else if (ext_cand) begin
            take = 1'b1;
            code = CW'(EC_EXTINT);
        end
    end
endmodule

// File: rtl/exc_return_pc.sv
module exc_return_pc #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic            dslot,
    input  logic            is_syscall,
    output logic [XLEN-1:0] epc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] back;

    assign back = dslot ? (pc - STEP) : pc;
    assign epc  = is_syscall ? (back + STEP) : back;
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int XLEN      = 32,
    parameter int CW        = 4,
    parameter int VEC_SHIFT = 8,
    parameter int HIGH_BITS = 4
) (
    input  logic [CW-1:0]   code,
    input  logic            base_en,
    input  logic [XLEN-1:0] base,
    input  logic            high_page,
    output logic [XLEN-1:0] vec
);
    localparam int PAD = XLEN - CW - VEC_SHIFT;
    localparam logic [XLEN-1:0] HIGH_MASK = {{HIGH_BITS{1'b1}}, {(XLEN-HIGH_BITS){1'b0}}};

    logic [XLEN-1:0] offset;

    assign offset = {{PAD{1'b0}}, code, {VEC_SHIFT{1'b0}}};
    assign vec    = offset
                  | (base_en   ? base      : '0)
                  | (high_page ? HIGH_MASK : '0);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              SR_W      = 16,
    parameter int              CW        = 4,
    parameter int              VEC_SHIFT = 8,
    parameter int              PM_W      = 2,
    parameter logic [SR_W-1:0] SR_RESET  = SR_W'(1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_valid_i,
    input  logic [CW-1:0]   exc_code_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic            dslot_i,
    input  logic            ext_irq_i,
    input  logic            tick_irq_i,
    input  logic            vbase_en_i,
    input  logic [XLEN-1:0] vbase_i,
    input  logic            sr_wr_i,
    input  logic [SR_W-1:0] sr_wdata_i,
    input  logic            pm_wr_i,
    input  logic [PM_W-1:0] pm_wdata_i,
    input  logic            lock_set_i,
    input  logic [XLEN-1:0] lock_addr_i,
    output logic            redirect_o,
    output logic [XLEN-1:0] new_pc_o,
    output logic [CW-1:0]   cause_o,
    output logic [XLEN-1:0] epc_o,
    output logic [XLEN-1:0] eear_o,
    output logic [SR_W-1:0] esr_o,
    output logic [SR_W-1:0] sr_o,
    output logic [PM_W-1:0] pm_o,
    output logic [XLEN-1:0] lock_addr_o,
    output logic            tlb_flush_o,
    output logic            dslot_clr_o,
    output logic            err_o
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic [SR_W-1:0] esr;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] eear;
        logic [XLEN-1:0] new_pc;
        logic [XLEN-1:0] lock;
        logic [PM_W-1:0] pm;
        logic [CW-1:0]   cause;
        logic            redirect;
        logic            flush;
        logic            dclr;
        logic            err;
    } state_t;

    state_t st_d, st_q;

    logic            take_w;
    logic            bad_w;
    logic [CW-1:0]   code_w;
    logic [XLEN-1:0] epc_w;
    logic [XLEN-1:0] vec_w;
    logic [SR_W-1:0] sr_mod;

    exc_arbiter #(.CW(CW)) u_arb (
        .exc_valid (exc_valid_i),
        .exc_code  (exc_code_i),
        .ext_irq   (ext_irq_i),
        .tick_irq  (tick_irq_i),
        .irq_en    (st_q.sr[SR_IRQ_EN]),
        .tick_en   (st_q.sr[SR_TICK_EN]),
        .take      (take_w),
        .bad       (bad_w),
        .code      (code_w)
    );

    exc_return_pc #(.XLEN(XLEN)) u_rpc (
        .pc         (pc_i),
        .dslot      (dslot_i),
        .is_syscall (code_w == CW'(EC_SYSCALL)),
        .epc        (epc_w)
    );

    exc_vector #(.XLEN(XLEN), .CW(CW), .VEC_SHIFT(VEC_SHIFT)) u_vec (
        .code      (code_w),
        .base_en   (vbase_en_i),
        .base      (vbase_i),
        .high_page (st_q.sr[SR_HIGH_VEC]),
        .vec       (vec_w)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.flush    = 1'b0;
        st_d.dclr     = 1'b0;
        st_d.err      = 1'b0;
        sr_mod        = st_q.sr;

        if (sr_wr_i)    st_d.sr   = sr_wdata_i;
        if (pm_wr_i)    st_d.pm   = pm_wdata_i;
        if (lock_set_i) st_d.lock = lock_addr_i;

        if (bad_w) begin
            st_d.err = 1'b1;
        end else if (take_w) begin
            sr_mod[SR_DSLOT_X] = dslot_i;
            st_d.esr           = sr_mod;
            sr_mod[SR_SUP]     = 1'b1;
            sr_mod[SR_TICK_EN] = 1'b0;
            sr_mod[SR_IRQ_EN]  = 1'b0;
            sr_mod[SR_DMMU_EN] = 1'b0;
            sr_mod[SR_IMMU_EN] = 1'b0;
            st_d.sr            = sr_mod;
            st_d.epc           = epc_w;
            if (code_w == CW'(EC_ILLEGAL)) st_d.eear = pc_i;
            st_d.new_pc        = vec_w;
            st_d.cause         = code_w;
            st_d.redirect      = 1'b1;
            st_d.flush         = 1'b1;
            st_d.dclr          = dslot_i;
            st_d.pm            = '0;
            st_d.lock          = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sr   <= SR_RESET;
            st_q.lock <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o  = st_q.redirect;
    assign new_pc_o    = st_q.new_pc;
    assign cause_o     = st_q.cause;
    assign epc_o       = st_q.epc;
    assign eear_o      = st_q.eear;
    assign esr_o       = st_q.esr;
    assign sr_o        = st_q.sr;
    assign pm_o        = st_q.pm;
    assign lock_addr_o = st_q.lock;
    assign tlb_flush_o = st_q.flush;
    assign dslot_clr_o = st_q.dclr;
    assign err_o       = st_q.err;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int SR_W = 16,
    parameter int CW   = 4,
    parameter int PM_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sr_wr_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] new_pc_o,
    input logic [CW-1:0]   cause_o,
    input logic [SR_W-1:0] esr_o,
    input logic [SR_W-1:0] sr_o,
    input logic [PM_W-1:0] pm_o,
    input logic [XLEN-1:0] lock_addr_o,
    input logic            tlb_flush_o,
    input logic            err_o
);
    localparam logic [SR_W-1:0] DSX_MASK = SR_W'(1) << SR_DSLOT_X;

    // R6: supervisor entry state
    a_r6_sup_entry: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (sr_o[SR_SUP] && !sr_o[SR_TICK_EN] && !sr_o[SR_IRQ_EN]
                        && !sr_o[SR_DMMU_EN] && !sr_o[SR_IMMU_EN]));

    // R6: snapshot is the prior status word apart from bit 5
    a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((esr_o & ~DSX_MASK) == ($past(sr_o) & ~DSX_MASK)));

    // R10: entry cleanup
    a_r10_entry_cleanup: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> (tlb_flush_o && (lock_addr_o == '1) && (pm_o == '0)));

    // R2: only defined codes are vectored
    a_r2_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> ((cause_o >= CW'(1)) && (cause_o <= CW'(EC_LAST))));

    // R7: high page bit forces the top nibble
    a_r7_high_page: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && $past(sr_o[SR_HIGH_VEC])) |-> (new_pc_o[XLEN-1 -: 4] == 4'hF));

    // R11: error excludes entry
    a_r11_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!redirect_o && !tlb_flush_o));

    // R11: error leaves status untouched
    a_r11_err_holds_sr: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !$past(sr_wr_i)) |-> (sr_o == $past(sr_o)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .SR_W(SR_W), .CW(CW), .PM_W(PM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sr_wr_i     (sr_wr_i),
    .redirect_o  (redirect_o),
    .new_pc_o    (new_pc_o),
    .cause_o     (cause_o),
    .esr_o       (esr_o),
    .sr_o        (sr_o),
    .pm_o        (pm_o),
    .lock_addr_o (lock_addr_o),
    .tlb_flush_o (tlb_flush_o),
    .err_o       (err_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_code_i = '0;
    logic [31:0] pc_i = '0;
    logic        dslot_i = 1'b0;
    logic        ext_irq_i = 1'b0;
    logic        tick_irq_i = 1'b0;
    logic        vbase_en_i = 1'b0;
    logic [31:0] vbase_i = '0;
    logic        sr_wr_i = 1'b0;
    logic [15:0] sr_wdata_i = '0;
    logic        pm_wr_i = 1'b0;
    logic [1:0]  pm_wdata_i = '0;
    logic        lock_set_i = 1'b0;
    logic [31:0] lock_addr_i = '0;
    logic        redirect_o;
    logic [31:0] new_pc_o;
    logic [3:0]  cause_o;
    logic [31:0] epc_o;
    logic [31:0] eear_o;
    logic [15:0] esr_o;
    logic [15:0] sr_o;
    logic [1:0]  pm_o;
    logic [31:0] lock_addr_o;
    logic        tlb_flush_o;
    logic        dslot_clr_o;
    logic        err_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    exc_entry_ctrl u0 (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // one-cycle request; returns at the negedge after the capturing edge
    task automatic fire(input logic v, input logic [3:0] code, input logic [31:0] pc,
                        input logic ds, input logic ext, input logic tick);
        @(negedge clk);
        exc_valid_i = v; exc_code_i = code; pc_i = pc; dslot_i = ds;
        ext_irq_i = ext; tick_irq_i = tick;
        @(posedge clk);
        #1;
        exc_valid_i = 1'b0; ext_irq_i = 1'b0; tick_irq_i = 1'b0; dslot_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_sr(input logic [15:0] v);
        @(negedge clk); sr_wr_i = 1'b1; sr_wdata_i = v;
        @(posedge clk); #1 sr_wr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "sr", 32'(sr_o), 32'h1);
        chk("R1", "lock", lock_addr_o, 32'hFFFF_FFFF);
        chk("R1", "pm", 32'(pm_o), 0);
        chk("R1", "epc", epc_o, 0);
        chk("R1", "esr", 32'(esr_o), 0);
        chk("R1", "pulses", {28'd0, redirect_o, tlb_flush_o, dslot_clr_o, err_o}, 0);
    endtask

    task automatic t_basic();
        @(negedge clk);
        pm_wr_i = 1'b1; pm_wdata_i = 2'b11; lock_set_i = 1'b1; lock_addr_i = 32'h55;
        @(posedge clk); #1 pm_wr_i = 1'b0; lock_set_i = 1'b0;
        @(negedge clk);
        chk("R12", "pm write", 32'(pm_o), 3);
        chk("R12", "lock write", lock_addr_o, 32'h55);
        fire(1'b1, 4'd2, 32'h1000, 1'b0, 1'b0, 1'b0);
        chk("R2", "redirect", 32'(redirect_o), 1);
        chk("R2", "cause", 32'(cause_o), 2);
        chk("R2", "epc", epc_o, 32'h1000);
        chk("R7", "vector", new_pc_o, 32'h200);
        chk("R10", "flush", 32'(tlb_flush_o), 1);
        chk("R10", "pm cleared", 32'(pm_o), 0);
        chk("R10", "lock", lock_addr_o, 32'hFFFF_FFFF);
        chk("R6", "esr", 32'(esr_o), 32'h1);
        @(negedge clk);
        chk("R2", "pulse ends", {30'd0, redirect_o, tlb_flush_o}, 0);
    endtask

    task automatic t_dslot();
        wr_sr(16'h001E);
        chk("R12", "sr write", 32'(sr_o), 32'h1E);
        fire(1'b1, 4'd6, 32'h2008, 1'b1, 1'b0, 1'b0);
        chk("R3", "epc", epc_o, 32'h2004);
        chk("R3", "dslot clr", 32'(dslot_clr_o), 1);
        chk("R6", "esr", 32'(esr_o), 32'h3E);
        chk("R6", "sr", 32'(sr_o), 32'h21);
        chk("R7", "vector", new_pc_o, 32'h600);
        fire(1'b1, 4'd6, 32'h3000, 1'b0, 1'b0, 1'b0);
        chk("R3", "dsx cleared sr", 32'(sr_o), 32'h1);
        chk("R3", "dsx cleared esr", 32'(esr_o), 32'h1);
        chk("R3", "no clr", 32'(dslot_clr_o), 0);
    endtask

    task automatic t_syscall();
        fire(1'b1, 4'd12, 32'h4000, 1'b0, 1'b0, 1'b0);
        chk("R4", "epc plain", epc_o, 32'h4004);
        fire(1'b1, 4'd12, 32'h4010, 1'b1, 1'b0, 1'b0);
        chk("R4", "epc dslot", epc_o, 32'h4010);
    endtask

    task automatic t_illegal();
        fire(1'b1, 4'd7, 32'h5000, 1'b0, 1'b0, 1'b0);
        chk("R5", "eear", eear_o, 32'h5000);
        fire(1'b1, 4'd2, 32'h6000, 1'b0, 1'b0, 1'b0);
        chk("R5", "eear held", eear_o, 32'h5000);
    endtask

    task automatic t_vector();
        wr_sr(16'h0001);
        @(negedge clk); vbase_en_i = 1'b1; vbase_i = 32'h8000_0000;
        fire(1'b1, 4'd9, 32'h10, 1'b0, 1'b0, 1'b0);
        chk("R7", "base", new_pc_o, 32'h8000_0900);
        @(negedge clk); vbase_en_i = 1'b0;
        wr_sr(16'h0041);
        fire(1'b1, 4'd3, 32'h20, 1'b0, 1'b0, 1'b0);
        chk("R7", "high page", new_pc_o, 32'hF000_0300);
        chk("R6", "eph kept", 32'(sr_o), 32'h41);
    endtask

    task automatic t_irq();
        wr_sr(16'h0000);
        fire(1'b0, 4'd0, 32'h100, 1'b0, 1'b1, 1'b1);
        chk("R8", "disabled no entry", 32'(redirect_o), 0);
        wr_sr(16'h0004);
        fire(1'b0, 4'd0, 32'h104, 1'b0, 1'b1, 1'b1);
        chk("R8", "ext cause", 32'(cause_o), 8);
        chk("R8", "ext vector", new_pc_o, 32'h800);
        wr_sr(16'h0006);
        fire(1'b0, 4'd0, 32'h108, 1'b0, 1'b1, 1'b1);
        chk("R8", "tick wins", 32'(cause_o), 5);
        wr_sr(16'h0002);
        fire(1'b0, 4'd0, 32'h10C, 1'b0, 1'b1, 1'b0);
        chk("R8", "ext masked", 32'(redirect_o), 0);
        wr_sr(16'h0006);
        fire(1'b1, 4'd13, 32'h110, 1'b0, 1'b1, 1'b1);
        chk("R9", "sync wins", 32'(cause_o), 13);
        chk("R9", "redirect", 32'(redirect_o), 1);
    endtask

    task automatic t_bad();
        wr_sr(16'h0006);
        @(negedge clk); lock_set_i = 1'b1; lock_addr_i = 32'h1234;
        @(posedge clk); #1 lock_set_i = 1'b0;
        fire(1'b1, 4'd0, 32'h200, 1'b0, 1'b0, 1'b0);
        chk("R11", "err code0", 32'(err_o), 1);
        chk("R11", "no redirect", {30'd0, redirect_o, tlb_flush_o}, 0);
        fire(1'b1, 4'd15, 32'h204, 1'b0, 1'b0, 1'b0);
        chk("R11", "err code15", 32'(err_o), 1);
        chk("R11", "sr kept", 32'(sr_o), 32'h6);
        chk("R11", "lock kept", lock_addr_i == 32'h1234 ? lock_addr_o : 32'h0, 32'h1234);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_dslot();
        t_syscall();
        t_illegal();
        t_vector();
        t_irq();
        t_bad();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule